// File: doc/BRIEF.md
# Format-Converting Rectangle Copy Engine

This block copies a rectangle of pixels from one buffer in byte-addressed memory to another and changes the pixel format on the way. Software programs a source base address, a destination base address, the source row pitch (in pixels), the width and height of the output rectangle, and one format code for the input and one for the output. It then writes the start register with bit 0 set. The engine walks the output rectangle row by row. Within each row it goes column by column. For every pixel it issues one read and then one write.

Source pixels are always 4 bytes wide and use the source pitch as their row stride. The destination may be packed as 3 bytes per pixel, in which case the fourth byte of each source pixel is discarded. It may also be kept at 4 bytes per pixel. The destination row stride is the output width. Format codes the engine cannot handle are flagged in a status register, and in that case no memory traffic takes place. A one-cycle completion pulse marks the end of every accepted start.

Top module: `fmt_copy_engine`

## Requirements
- R1: After reset, `busy`, `done`, `rd_req` and `wr_req` are 0 and the status register (word 6) reads 0.
- R2: A write to word 5 with bit 0 set starts a transfer when the engine is idle. A write to word 5 with bit 0 clear causes no memory request and no `done` pulse.
- R3: A transfer makes exactly width×height read/write pairs. Column runs fastest, then row. Each pair is a read followed by the write of the same pixel.
- R4: The read address of pixel (row y, column x) is source_base + (y·src_pitch + x)·4.
- R5: With output format code 1 (3-byte), pixel (y,x) is written at dest_base + (y·width + x)·3. `wr_be`=0111, and `wr_data[23:0]` holds source bytes 0..2 in order. The source byte at offset 3 is dropped (`wr_data[31:24]`=0).
- R6: With output format code 0 (4-byte), pixel (y,x) is written at dest_base + (y·width + x)·4. `wr_be`=1111, and `wr_data` equals the source word.
- R7: An input format code other than 0 sets status bit 1. It produces no memory request and still produces a `done` pulse.
- R8: An output format code other than 0 or 1 sets status bit 2. It produces no memory request and still produces a `done` pulse.
- R9: `done` is high for exactly one cycle after the last write is accepted, and `busy` is low in the following cycle.
- R10: A start written while `busy` is high is ignored. A register change made during a transfer does not alter the running transfer.
- R11: A start with width 0 or height 0 gives a `done` pulse with no memory request.
- R12: `rd_req` and `wr_req` are never high together. A request keeps its address, data and byte enables stable until `rd_valid` or `wr_ack` arrives.
- R13: The configuration words read back what was written: word 0 source, word 1 destination, word 2 pitch, word 3 {height[31:16], width[15:0]}, word 4 {out format[6:4], in format[2:0]}. The error flags are replaced at the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_waddr | input | 3 | Register write word index |
| cfg_wdata | input | 32 | Register write data |
| cfg_raddr | input | 3 | Register read word index |
| cfg_rdata | output | 32 | Register read data |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | ADDR_W | Read byte address |
| rd_valid | input | 1 | Read data valid, completes the read |
| rd_data | input | 32 | Read word, byte 0 in bits 7:0 |
| wr_req | output | 1 | Memory write request |
| wr_addr | output | ADDR_W | Write byte address of byte lane 0 |
| wr_data | output | 32 | Write word, lane 0 in bits 7:0 |
| wr_be | output | 4 | Byte lane enables |
| wr_ack | input | 1 | Write accepted |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |

## Verification
The bench builds the engine with ADDR_W=12 and DIM_W=6. This lets a 4 KiB byte array model the whole address space, and it keeps the full row and column counters small enough that random widths, heights and pitches cover row wrap and single-pixel rectangles in a few thousand cycles. Random stall patterns on both handshakes test that requests stay held. A restart written in the middle of a run, with rewritten base registers, tests that the latched snapshot is kept.

// File: rtl/xfer_pkg.sv
package xfer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2,
    ST_FIN   = 2'd3
  } xfer_state_e;

  localparam logic [2:0] FMT_PIX32 = 3'd0;
  localparam logic [2:0] FMT_PIX24 = 3'd1;

  // Byte offset of a pixel inside a buffer laid out row after row.
  function automatic logic [31:0] pix_offset(input logic [31:0] row,
                                             input logic [31:0] col,
                                             input logic [31:0] pitch,
                                             input logic [2:0]  bpp);
    return (row * pitch + col) * {29'd0, bpp};
  endfunction

  function automatic logic [31:0] pack_word(input logic [31:0] src_word,
                                            input logic        to24);
    return to24 ? {8'h00, src_word[23:0]} : src_word;
  endfunction

  function automatic logic [3:0] pack_lanes(input logic to24);
    return to24 ? 4'b0111 : 4'b1111;
  endfunction

  function automatic logic in_fmt_ok(input logic [2:0] code);
    return code == FMT_PIX32;
  endfunction

  function automatic logic out_fmt_ok(input logic [2:0] code);
    return (code == FMT_PIX32) || (code == FMT_PIX24);
  endfunction

endpackage

// File: rtl/xfer_regs.sv
module xfer_regs #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [2:0]        waddr,
  input  logic [31:0]       wdata,
  input  logic [2:0]        raddr,
  output logic [31:0]       rdata,
  input  logic              busy,
  input  logic              in_err,
  input  logic              out_err,
  output logic [ADDR_W-1:0] src_base,
  output logic [ADDR_W-1:0] dst_base,
  output logic [DIM_W-1:0]  src_pitch,
  output logic [DIM_W-1:0]  out_w,
  output logic [DIM_W-1:0]  out_h,
  output logic [2:0]        in_fmt,
  output logic [2:0]        out_fmt,
  output logic              start_req
);

  localparam logic [2:0] W_SRC = 3'd0;
  localparam logic [2:0] W_DST = 3'd1;
  localparam logic [2:0] W_PIT = 3'd2;
  localparam logic [2:0] W_DIM = 3'd3;
  localparam logic [2:0] W_FMT = 3'd4;
  localparam logic [2:0] W_GO  = 3'd5;
  localparam logic [2:0] W_STA = 3'd6;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_base  <= '0;
      dst_base  <= '0;
      src_pitch <= '0;
      out_w     <= '0;
      out_h     <= '0;
      in_fmt    <= '0;
      out_fmt   <= '0;
    end else if (we) begin
      case (waddr)
        W_SRC: src_base <= wdata[ADDR_W-1:0];
        W_DST: dst_base <= wdata[ADDR_W-1:0];
        W_PIT: src_pitch <= wdata[DIM_W-1:0];
        W_DIM: begin
          out_w <= wdata[DIM_W-1:0];
          out_h <= wdata[16+DIM_W-1:16];
        end
        W_FMT: begin
          in_fmt  <= wdata[2:0];
          out_fmt <= wdata[6:4];
        end
        default: ;
      endcase
    end
  end

  assign start_req = we && (waddr == W_GO) && wdata[0];

  always_comb begin
    rdata = '0;
    case (raddr)
      W_SRC: rdata = 32'(src_base);
      W_DST: rdata = 32'(dst_base);
      W_PIT: rdata = 32'(src_pitch);
      W_DIM: begin
        rdata[DIM_W-1:0]     = out_w;
        rdata[16+DIM_W-1:16] = out_h;
      end
      W_FMT: begin
        rdata[2:0] = in_fmt;
        rdata[6:4] = out_fmt;
      end
      W_STA: rdata[2:0] = {out_err, in_err, busy};
      default: rdata = '0;
    endcase
  end

endmodule

// File: rtl/xfer_walker.sv
module xfer_walker
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              active,
  input  logic [ADDR_W-1:0] src_base,
  input  logic [ADDR_W-1:0] dst_base,
  input  logic [DIM_W-1:0]  src_pitch,
  input  logic [DIM_W-1:0]  out_w,
  input  logic [DIM_W-1:0]  out_h,
  input  logic              to24_in,
  output logic [ADDR_W-1:0] src_addr,
  output logic [ADDR_W-1:0] dst_addr,
  output logic              to24,
  output logic              last_pix
);

  localparam logic [DIM_W-1:0] ONE = DIM_W'(1);

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [DIM_W-1:0]  pitch_q, w_q, h_q;
  logic [DIM_W-1:0]  col_q, row_q;
  logic              row_end;
  logic [31:0]       src_off, dst_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= '0;
      dst_q   <= '0;
      pitch_q <= '0;
      w_q     <= '0;
      h_q     <= '0;
      to24    <= 1'b0;
      col_q   <= '0;
      row_q   <= '0;
    end else if (load) begin
      src_q   <= src_base;
      dst_q   <= dst_base;
      pitch_q <= src_pitch;
      w_q     <= out_w;
      h_q     <= out_h;
      to24    <= to24_in;
      col_q   <= '0;
      row_q   <= '0;
    end else if (step) begin
      if (row_end) begin
        col_q <= '0;
        row_q <= row_q + ONE;
      end else begin
        col_q <= col_q + ONE;
      end
    end
  end

  assign row_end  = (col_q == w_q - ONE);
  assign last_pix = row_end && (row_q == h_q - ONE);

  assign src_off  = pix_offset(32'(row_q), 32'(col_q), 32'(pitch_q), 3'd4);
  assign dst_off  = pix_offset(32'(row_q), 32'(col_q), 32'(w_q), to24 ? 3'd3 : 3'd4);
  assign src_addr = src_q + src_off[ADDR_W-1:0];
  assign dst_addr = dst_q + dst_off[ADDR_W-1:0];

  // R3: column runs fastest and wraps into the next row
  a_r3_row_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step && !load && row_end && !last_pix) |=> (col_q == '0) && (row_q == $past(row_q) + ONE));

  a_r3_col_step: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step && !load && !row_end) |=> (col_q == $past(col_q) + ONE) && $stable(row_q));

  a_r3_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (col_q < w_q) && (row_q < h_q));

endmodule

// File: rtl/xfer_pack.sv
module xfer_pack
  import xfer_pkg::*;
(
  input  logic [31:0] src_word,
  input  logic        to24,
  output logic [31:0] dst_word,
  output logic [3:0]  lanes
);

  assign dst_word = pack_word(src_word, to24);
  assign lanes    = pack_lanes(to24);

  // R5: the fourth source byte never reaches a 3-byte destination
  always_comb begin
    a_r5_no_alpha: assert (!to24 || (dst_word[31:24] == 8'h00 && !lanes[3]));
  end

endmodule

// File: rtl/fmt_copy_engine.sv
module fmt_copy_engine
  import xfer_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_waddr,
  input  logic [31:0]       cfg_wdata,
  input  logic [2:0]        cfg_raddr,
  output logic [31:0]       cfg_rdata,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [31:0]       wr_data,
  output logic [3:0]        wr_be,
  input  logic              wr_ack,
  output logic              done,
  output logic              busy
);

  xfer_state_e       state_q, state_d;
  logic [ADDR_W-1:0] src_base, dst_base;
  logic [DIM_W-1:0]  src_pitch, out_w, out_h;
  logic [2:0]        in_fmt, out_fmt;
  logic              start_req, start_ok, fmt_bad, size_zero, go_walk;
  logic              in_err_q, out_err_q;
  logic [31:0]       pix_q;
  logic              walk_load, walk_step, walk_to24, last_pix;
  logic [ADDR_W-1:0] src_addr, dst_addr;

  xfer_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(cfg_we), .waddr(cfg_waddr), .wdata(cfg_wdata),
    .raddr(cfg_raddr), .rdata(cfg_rdata),
    .busy(busy), .in_err(in_err_q), .out_err(out_err_q),
    .src_base(src_base), .dst_base(dst_base), .src_pitch(src_pitch),
    .out_w(out_w), .out_h(out_h), .in_fmt(in_fmt), .out_fmt(out_fmt),
    .start_req(start_req)
  );

  assign start_ok  = start_req && (state_q == ST_IDLE);
  assign fmt_bad   = !in_fmt_ok(in_fmt) || !out_fmt_ok(out_fmt);
  assign size_zero = (out_w == '0) || (out_h == '0);
  assign go_walk   = start_ok && !fmt_bad && !size_zero;
  assign walk_load = go_walk;
  assign walk_step = (state_q == ST_WRITE) && wr_ack;

  xfer_walker #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_walk (
    .clk(clk), .rst_n(rst_n),
    .load(walk_load), .step(walk_step),
    .active(state_q == ST_READ || state_q == ST_WRITE),
    .src_base(src_base), .dst_base(dst_base), .src_pitch(src_pitch),
    .out_w(out_w), .out_h(out_h), .to24_in(out_fmt == FMT_PIX24),
    .src_addr(src_addr), .dst_addr(dst_addr),
    .to24(walk_to24), .last_pix(last_pix)
  );

  xfer_pack u_pack (
    .src_word(pix_q), .to24(walk_to24),
    .dst_word(wr_data), .lanes(wr_be)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: begin
        if (go_walk)       state_d = ST_READ;
        else if (start_ok) state_d = ST_FIN;
      end
      ST_READ:  if (rd_valid) state_d = ST_WRITE;
      ST_WRITE: if (wr_ack)   state_d = last_pix ? ST_FIN : ST_READ;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      pix_q     <= '0;
      in_err_q  <= 1'b0;
      out_err_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_READ && rd_valid) pix_q <= rd_data;
      if (start_ok) begin
        in_err_q  <= !in_fmt_ok(in_fmt);
        out_err_q <= !out_fmt_ok(out_fmt);
      end
    end
  end

  assign rd_req  = (state_q == ST_READ);
  assign wr_req  = (state_q == ST_WRITE);
  assign rd_addr = src_addr;
  assign wr_addr = dst_addr;
  assign done    = (state_q == ST_FIN);
  assign busy    = (state_q != ST_IDLE);

  // R12: a single request at a time, held until answered
  a_r12_one_req: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  a_r12_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> rd_req && $stable(rd_addr));

  a_r12_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> wr_req && $stable(wr_addr) && $stable(wr_data) && $stable(wr_be));

  // R9: completion is a single-cycle pulse followed by idle
  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy);

  // R7/R8: a bad format code ends the start with no traffic
  a_r7_bad_fmt: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && fmt_bad) |=> done && !rd_req && !wr_req);

  // R11: an empty rectangle finishes at once
  a_r11_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ok && size_zero) |=> done && !rd_req);

  // R2: an accepted start opens with a read
  a_r2_start_read: assert property (@(posedge clk) disable iff (!rst_n)
    go_walk |=> rd_req);

  // R10: a start while running leaves the sequence alone
  a_r10_busy_ignore: assert property (@(posedge clk) disable iff (!rst_n)
    (start_req && rd_req && !rd_valid) |=> rd_req && $stable(rd_addr));

endmodule

// File: tb/sim_fmt_copy_engine.sv
module sim_fmt_copy_engine;

  localparam int CLK_P  = 10;
  localparam int ADDR_W = 12;
  localparam int DIM_W  = 6;
  localparam int MEM_SZ = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_waddr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic [2:0]        cfg_raddr = '0;
  logic [31:0]       cfg_rdata;
  logic              rd_req, wr_req, done, busy;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic              rd_valid = 1'b0;
  logic [31:0]       rd_data = '0;
  logic [31:0]       wr_data;
  logic [3:0]        wr_be;
  logic              wr_ack = 1'b0;

  fmt_copy_engine #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_waddr(cfg_waddr), .cfg_wdata(cfg_wdata),
    .cfg_raddr(cfg_raddr), .cfg_rdata(cfg_rdata),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .wr_ack(wr_ack), .done(done), .busy(busy)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [MEM_SZ];

  // expected transfer parameters
  int exp_src, exp_dst, exp_pitch, exp_w, exp_h;
  bit exp_to24;
  int rd_k = 0, wr_k = 0, traffic = 0, done_cnt = 0;
  bit finished = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic int src_of(input int k);
    return exp_src + ((k / exp_w) * exp_pitch + (k % exp_w)) * 4;
  endfunction

  function automatic int dst_of(input int k);
    int bpp = exp_to24 ? 3 : 4;
    return exp_dst + ((k / exp_w) * exp_w + (k % exp_w)) * bpp;
  endfunction

  function automatic logic [31:0] word_at(input int a);
    return {mem[a+3], mem[a+2], mem[a+1], mem[a]};
  endfunction

  // memory model and monitor, all at the falling edge
  always @(negedge clk) begin
    if (done) done_cnt++;
    rd_valid = 1'b0;
    wr_ack   = 1'b0;
    if (rst_n && rd_req) begin
      if (($urandom % 3) != 0) begin
        rd_valid = 1'b1;
        rd_data  = word_at(int'(rd_addr));
        traffic++;
        check(rd_k == wr_k, "R3", "read before previous write", rd_k, wr_k);
        check(int'(rd_addr) == src_of(rd_k), "R4", "read address", rd_addr, src_of(rd_k));
        rd_k++;
      end
    end
    if (rst_n && wr_req) begin
      if (($urandom % 3) != 0) begin
        logic [31:0] sw;
        wr_ack = 1'b1;
        traffic++;
        sw = word_at(src_of(wr_k));
        if (exp_to24) begin
          check(int'(wr_addr) == dst_of(wr_k), "R5", "write address", wr_addr, dst_of(wr_k));
          check(wr_be == 4'b0111, "R5", "byte lanes", wr_be, 4'b0111);
          check(wr_data == {8'h00, sw[23:0]}, "R5", "packed data", wr_data, {8'h00, sw[23:0]});
        end else begin
          check(int'(wr_addr) == dst_of(wr_k), "R6", "write address", wr_addr, dst_of(wr_k));
          check(wr_be == 4'b1111, "R6", "byte lanes", wr_be, 4'b1111);
          check(wr_data == sw, "R6", "word data", wr_data, sw);
        end
        for (int b = 0; b < 4; b++)
          if (wr_be[b]) mem[int'(wr_addr) + b] = wr_data[8*b +: 8];
        wr_k++;
      end
    end
  end

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_waddr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    cfg_raddr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic wait_done(input string req);
    int start = done_cnt;
    int n = 0;
    while (done_cnt == start && n < 3000) begin
      @(negedge clk);
      n++;
    end
    @(negedge clk);
    check(done_cnt == start + 1, req, "done pulses", done_cnt - start, 1);
  endtask

  task automatic setup(input int s, input int d, input int p, input int w,
                       input int h, input bit t24);
    exp_src = s; exp_dst = d; exp_pitch = p; exp_w = w; exp_h = h; exp_to24 = t24;
    rd_k = 0; wr_k = 0;
    for (int i = 0; i < 1024; i++) mem[12'h800 + i] = 8'hEE;
    reg_wr(3'd0, 32'(s));
    reg_wr(3'd1, 32'(d));
    reg_wr(3'd2, 32'(p));
    reg_wr(3'd3, (32'(h) << 16) | 32'(w));
    reg_wr(3'd4, t24 ? 32'h10 : 32'h00);
  endtask

  task automatic run_copy(input string req);
    logic [31:0] st;
    reg_wr(3'd5, 32'h1);
    wait_done(req);
    check(wr_k == exp_w * exp_h, "R3", "write count", wr_k, exp_w * exp_h);
    check(rd_k == exp_w * exp_h, "R3", "read count", rd_k, exp_w * exp_h);
    check(mem[exp_dst + exp_w * exp_h * (exp_to24 ? 3 : 4)] == 8'hEE, req,
          "byte past image untouched", mem[exp_dst + exp_w * exp_h * (exp_to24 ? 3 : 4)], 8'hEE);
    reg_rd(3'd6, st);
    check(st == 32'h0, "R9", "status after done", st, 0);
  endtask

  initial begin
    logic [31:0] v;
    int t0;
    void'($urandom(32'd2024));
    for (int i = 0; i < MEM_SZ; i++) mem[i] = 8'(i * 37 + 11);
    exp_w = 1; exp_h = 1; exp_pitch = 1; exp_src = 0; exp_dst = 0; exp_to24 = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    reg_rd(3'd6, v);
    check(v == 0, "R1", "status at reset", v, 0);
    check(!busy && !done && !rd_req && !wr_req, "R1", "outputs at reset",
          {busy, done, rd_req, wr_req}, 0);

    // R13 readback
    setup(12'h104, 12'h820, 7, 5, 3, 1'b1);
    reg_rd(3'd0, v); check(v == 32'h104, "R13", "source readback", v, 32'h104);
    reg_rd(3'd2, v); check(v == 7, "R13", "pitch readback", v, 7);
    reg_rd(3'd3, v); check(v == 32'h0003_0005, "R13", "size readback", v, 32'h0003_0005);
    reg_rd(3'd4, v); check(v == 32'h10, "R13", "format readback", v, 32'h10);

    // R2 start with bit 0 clear does nothing
    t0 = done_cnt;
    reg_wr(3'd5, 32'hFFFF_FFFE);
    repeat (10) @(negedge clk);
    check(traffic == 0 && done_cnt == t0 && !busy, "R2", "cleared start bit idle",
          traffic, 0);

    // R5 directed 3-byte copy with wider source pitch
    run_copy("R5");
    // R6 4-byte copy
    setup(12'h200, 12'h900, 3, 3, 2, 1'b0);
    run_copy("R6");
    // R3 single pixel
    setup(12'h0FC, 12'h800, 1, 1, 1, 1'b1);
    run_copy("R3");

    // random runs
    for (int r = 0; r < 8; r++) begin
      int w = 1 + int'($urandom % 7);
      int h = 1 + int'($urandom % 5);
      int p = w + int'($urandom % 4);
      setup(int'($urandom % 256) * 4, 12'h800 + int'($urandom % 64), p, w, h,
            bit'($urandom % 2));
      run_copy(exp_to24 ? "R5" : "R6");
    end

    // R7 bad input format
    t0 = traffic;
    reg_wr(3'd4, 32'h12);
    reg_wr(3'd5, 32'h1);
    wait_done("R7");
    reg_rd(3'd6, v);
    check(v == 32'h2, "R7", "status input error", v, 32'h2);
    check(traffic == t0, "R7", "no traffic", traffic - t0, 0);

    // R8 bad output format
    reg_wr(3'd4, 32'h50);
    reg_wr(3'd5, 32'h1);
    wait_done("R8");
    reg_rd(3'd6, v);
    check(v == 32'h4, "R8", "status output error", v, 32'h4);
    check(traffic == t0, "R8", "no traffic", traffic - t0, 0);

    // R13 flags replaced at next accepted start; R11 empty rectangle
    setup(12'h100, 12'h800, 4, 0, 3, 1'b1);
    t0 = traffic;
    reg_wr(3'd5, 32'h1);
    wait_done("R11");
    reg_rd(3'd6, v);
    check(v == 0, "R13", "errors cleared", v, 0);
    check(traffic == t0, "R11", "zero width no traffic", traffic - t0, 0);
    reg_wr(3'd3, 32'h0000_0004);
    reg_wr(3'd5, 32'h1);
    wait_done("R11");
    check(traffic == t0, "R11", "zero height no traffic", traffic - t0, 0);

    // R10 restart while busy
    setup(12'h040, 12'h800, 8, 6, 4, 1'b1);
    t0 = done_cnt;
    reg_wr(3'd5, 32'h1);
    repeat (6) @(negedge clk);
    reg_rd(3'd6, v);
    check(v[0] == 1'b1, "R10", "busy during run", v[0], 1);
    reg_wr(3'd0, 32'h300);
    reg_wr(3'd5, 32'h1);
    while (done_cnt == t0) @(negedge clk);
    repeat (20) @(negedge clk);
    check(done_cnt == t0 + 1, "R10", "one done only", done_cnt - t0, 1);
    check(wr_k == 24, "R10", "pixels of first start", wr_k, 24);
    reg_rd(3'd0, v);
    check(v == 32'h300, "R13", "source rewritten", v, 32'h300);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule